// File: doc/BRIEF.md
# Loadable Microsecond Timestamp Counter

The block keeps a 64-bit time-of-day count that advances by one every microsecond. The microsecond tick is produced by dividing the core clock by `CLK_PER_US`. Software sets a new time in two writes to staging registers. The first write fills a 32-bit low stage. The second goes to a high stage that holds 31 value bits plus a control bit in bit 31, the arm bit. The counter takes the new value only when the arm bit is written as 1 and then later written as 0. Both halves therefore reach the counter together, in a single cycle, once software has finished staging them.

Reading uses a snapshot scheme. A read strobe goes with the read of the live low half. On the same clock edge, the upper half is copied into a holding register. A 64-bit value read as two halves is therefore never torn by a carry between them. The block pulses `reload_pulse` for exactly one cycle: the first cycle in which the newly loaded value is visible.

A load sequencer tracks the arm bit with three states:
- `LS_IDLE`: the arm bit is clear. A high write with bit 31 = 1 moves to `LS_ARMED`. Any other write stays in `LS_IDLE`.
- `LS_ARMED`: the arm bit is set. A high write with bit 31 = 0 is the falling edge and moves to `LS_FIRE`. Any other write stays in `LS_ARMED`.
- `LS_FIRE`: the load is committed at the end of this cycle. The state then returns to `LS_IDLE`, or goes to `LS_ARMED` if a high write with bit 31 = 1 arrives in this cycle.

Top module: `usec_timer64`

## Requirements
- R1: After reset, `tsf`, `rd_hi` and `reload_pulse` are all zero.
- R2: With no load in progress, `tsf` increases by exactly one every `CLK_PER_US` clock cycles.
- R3: A write to the low stage, with no arm-bit falling edge, leaves the progression of `tsf` unchanged.
- R4: A high write with bit 31 = 1 only arms the load. It leaves the progression of `tsf` unchanged.
- R5: A high write with bit 31 = 0 that follows an arming write loads the counter. The value is {1'b0, bits 30:0 of that falling write, the low stage}. It is visible after the second rising edge counted from the edge that accepts the write.
- R6: `reload_pulse` is high for exactly one cycle per load, namely the cycle in which `tsf` first shows the loaded value. It is low at all other times.
- R7: A high write with bit 31 = 0 while the sequencer is not armed does not load.
- R8: A load takes priority over a coincident increment and restarts the divider. The loaded value is held for `CLK_PER_US` cycles before the first increment.
- R9: Bit 63 of `tsf` is always loaded as 0.
- R10: `rd_lo` always shows `tsf[31:0]`. On a clock edge where `rd_strobe` is high, `rd_hi` captures `tsf[63:32]` from the same cycle, and it holds that value until the next strobe.
- R11: An increment from a low half of all ones carries into the high half.
- R12: Every high write updates the high stage, so the falling write's data is the value loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_wr | input | 1 | Write strobe for the low stage |
| lo_wdata | input | 32 | Low stage write data |
| hi_wr | input | 1 | Write strobe for the high stage |
| hi_wdata | input | 32 | Bits 30:0 are high value bits; bit 31 is the arm bit |
| rd_strobe | input | 1 | Read of the low half; snapshots the upper half |
| rd_lo | output | 32 | Live low half of the count |
| rd_hi | output | 32 | Upper half captured at the last read strobe |
| tsf | output | 64 | Live 64-bit microsecond count |
| reload_pulse | output | 1 | One-cycle marker of a completed load |

## Verification
The bench tracks the expected count as the loaded value plus elapsed cycles divided by the tick period, and compares it at every cycle inside each window.
- A sequencer stuck in the wrong state would show as a missing load or a spurious load. Either appears as a wrong `tsf` value one cycle after the write stream, together with a missing or extra `reload_pulse`.
- A divider whose phase was not restarted by a load would shift the first increment. It would be caught within `CLK_PER_US` cycles of the load.
- A wrong staged half would show up at once as a mismatch in the loaded value.
- A snapshot taken on the wrong edge would show on the following read as a `rd_hi` value that does not match the `rd_lo` value read in the strobe cycle.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
    localparam int TSF_W  = 64;
    localparam int HALF_W = TSF_W / 2;
    localparam int ARM_BIT = HALF_W - 1;

    typedef enum logic [1:0] {
        LS_IDLE  = 2'd0,
        LS_ARMED = 2'd1,
        LS_FIRE  = 2'd2
    } ld_state_t;
endpackage

// File: rtl/usec_prescaler.sv
module usec_prescaler #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (restart || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    generate
        if (DIV > 1) begin : g_gap
            // R2: ticks are isolated pulses when the divider is above one
            assert_tick_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/tsf_load_seq.sv
module tsf_load_seq
    import usec_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_wr,
    input  logic [HALF_W-1:0] lo_wdata,
    input  logic              hi_wr,
    input  logic [HALF_W-1:0] hi_wdata,
    output logic              load_en,
    output logic [TSF_W-1:0]  load_val
);
    ld_state_t state, state_nx;
    logic [HALF_W-1:0] lo_stage;
    logic [HALF_W-2:0] hi_stage;

    // staging registers: updated on every write (R12)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_stage <= '0;
            hi_stage <= '0;
        end else begin
            if (lo_wr) lo_stage <= lo_wdata;
            if (hi_wr) hi_stage <= hi_wdata[ARM_BIT-1:0];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LS_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            LS_IDLE:  if (hi_wr && hi_wdata[ARM_BIT])  state_nx = LS_ARMED;
            LS_ARMED: if (hi_wr && !hi_wdata[ARM_BIT]) state_nx = LS_FIRE;
            LS_FIRE:  state_nx = (hi_wr && hi_wdata[ARM_BIT]) ? LS_ARMED : LS_IDLE;
            default:  state_nx = LS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_en  = (state == LS_FIRE);
        load_val = {1'b0, hi_stage, lo_stage};   // R9: top bit forced low
    end

    // R5: a commit is only reached from the armed state
    assert_fire_from_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_FIRE) |-> ($past(state) == LS_ARMED));
    // R7: an idle sequencer never commits on the next cycle
    assert_idle_no_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LS_IDLE) |=> (state != LS_FIRE));
    // R6: commits never occur back to back
    assert_single_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !load_en);
endmodule

// File: rtl/tsf_count_core.sv
module tsf_count_core
    import usec_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [TSF_W-1:0]  load_val,
    input  logic              tick,
    input  logic              rd_strobe,
    output logic [TSF_W-1:0]  tsf,
    output logic [HALF_W-1:0] rd_hi,
    output logic              reload_pulse
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tsf          <= '0;
            reload_pulse <= 1'b0;
        end else begin
            reload_pulse <= load_en;
            if (load_en)   tsf <= load_val;      // R8: load wins over tick
            else if (tick) tsf <= tsf + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         rd_hi <= '0;
        else if (rd_strobe) rd_hi <= tsf[TSF_W-1:HALF_W];
    end

    // R5/R6: the pulse marks the cycle the staged value became visible
    assert_loaded_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pulse |-> (tsf == $past(load_val)));
    // R2: without a tick or load the count holds
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !tick) |=> $stable(tsf));
    // R2/R11: a tick advances by exactly one, carrying across halves
    assert_step_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en) |=> (tsf == $past(tsf) + 64'd1));
    // R10: snapshot equals the upper half seen at the strobe
    assert_snapshot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> (rd_hi == $past(tsf[TSF_W-1:HALF_W])));
endmodule

// File: rtl/usec_timer64.sv
module usec_timer64
    import usec_timer_pkg::*;
#(
    parameter int CLK_PER_US = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lo_wr,
    input  logic [31:0] lo_wdata,
    input  logic        hi_wr,
    input  logic [31:0] hi_wdata,
    input  logic        rd_strobe,
    output logic [31:0] rd_lo,
    output logic [31:0] rd_hi,
    output logic [63:0] tsf,
    output logic        reload_pulse
);
    logic             load_en;
    logic [TSF_W-1:0] load_val;
    logic             tick;

    tsf_load_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_wr    (lo_wr),
        .lo_wdata (lo_wdata),
        .hi_wr    (hi_wr),
        .hi_wdata (hi_wdata),
        .load_en  (load_en),
        .load_val (load_val)
    );

    usec_prescaler #(.DIV(CLK_PER_US)) i_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_en),
        .tick    (tick)
    );

    tsf_count_core i_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_en      (load_en),
        .load_val     (load_val),
        .tick         (tick),
        .rd_strobe    (rd_strobe),
        .tsf          (tsf),
        .rd_hi        (rd_hi),
        .reload_pulse (reload_pulse)
    );

    assign rd_lo = tsf[HALF_W-1:0];

    // R9: a completed load never sets the top bit
    assert_top_bit_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pulse |-> !tsf[TSF_W-1]);
endmodule

// File: tb/test_usec_timer64.sv
`timescale 1ns/1ps
module test_usec_timer64;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lo_wr = 1'b0, hi_wr = 1'b0, rd_strobe = 1'b0;
    logic [31:0] lo_wdata = '0, hi_wdata = '0;
    logic [31:0] rd_lo, rd_hi;
    logic [63:0] tsf;
    logic        reload_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    usec_timer64 #(.CLK_PER_US(DIV)) i_usec_timer64 (
        .clk(clk), .rst_n(rst_n),
        .lo_wr(lo_wr), .lo_wdata(lo_wdata),
        .hi_wr(hi_wr), .hi_wdata(hi_wdata),
        .rd_strobe(rd_strobe),
        .rd_lo(rd_lo), .rd_hi(rd_hi),
        .tsf(tsf), .reload_pulse(reload_pulse)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_lo(input logic [31:0] d);
        @(negedge clk); lo_wr = 1'b1; lo_wdata = d;
        @(negedge clk); lo_wr = 1'b0;
    endtask

    task automatic wr_hi(input logic [31:0] d);
        @(negedge clk); hi_wr = 1'b1; hi_wdata = d;
        @(negedge clk); hi_wr = 1'b0;
    endtask

    // stage and commit; the arming write carries other data (R12)
    task automatic load(input logic [30:0] hi, input logic [31:0] lo);
        wr_lo(lo);
        wr_hi({1'b1, ~hi});
        wr_hi({1'b0, hi});
        @(negedge clk);   // second edge after the write edge has passed
    endtask

    // per-cycle window after a load; mode picks side stimulus
    task automatic window(input logic [63:0] v, input int mode);
        logic [31:0] lo_seen;
        logic [63:0] e;
        lo_seen = '0;
        for (int k = 0; k <= 3 * DIV; k++) begin
            e = v + 64'(k / DIV);
            chk((k < DIV) ? "R8 hold" : "R2 count", tsf, e);
            chk("R6 pulse", {63'd0, reload_pulse}, {63'd0, (k == 0)});
            chk("R10 live low", {32'd0, rd_lo}, {32'd0, e[31:0]});
            if (k == 0) chk("R9 top bit", {63'd0, tsf[63]}, 64'd0);
            lo_wr = 1'b0; hi_wr = 1'b0; rd_strobe = 1'b0;
            if (k == 1 && mode == 1) begin lo_wr = 1'b1; lo_wdata = 32'hDEAD_BEEF; end   // R3
            if (k == 1 && mode == 2) begin hi_wr = 1'b1; hi_wdata = 32'h8000_1234; end   // R4
            if (k == 1 && mode == 3) begin hi_wr = 1'b1; hi_wdata = 32'h0000_5555; end   // R7
            if (k == DIV + 1 && mode == 4) begin rd_strobe = 1'b1; lo_seen = rd_lo; end
            if (k == DIV + 2 && mode == 4)
                chk("R10 snapshot", {rd_hi, lo_seen}, v + 64'((DIV + 1) / DIV));
            @(negedge clk);
        end
        lo_wr = 1'b0; hi_wr = 1'b0; rd_strobe = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 tsf", tsf, 64'd0);
        chk("R1 rd_hi", {32'd0, rd_hi}, 64'd0);
        chk("R1 pulse", {63'd0, reload_pulse}, 64'd0);
        rst_n = 1'b1;

        // sweep of load values with each side stimulus
        for (int i = 0; i < 10; i++) begin
            logic [30:0] h;
            logic [31:0] l;
            h = 31'(i * 32'h1357_9BDF) | ((i % 3 == 0) ? 31'h4000_0000 : 31'h0);
            l = (i % 2 == 1) ? 32'hFFFF_FFFE : 32'(i * 32'h0102_0304);   // R11 carry case
            load(h, l);
            window({1'b0, h, l}, i % 5);
        end

        // R7 again: lone zero write right after reset of the sequence leaves count running
        load(31'h7FFF_FFFF, 32'hFFFF_FFFF);
        window({1'b0, 31'h7FFF_FFFF, 32'hFFFF_FFFF}, 3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule